// File: doc/BRIEF.md
# Cascaded 16x Baud Enable Generator

This block turns a fast system clock into a one-cycle enable strobe, `tick16`, that fires at sixteen times a UART bit rate. Two programmable down-counters in series set the rate. The first stage divides the clock by a 4-bit prescale code plus one. The second stage divides the first stage's terminal events by an 8-bit divide code plus one. The strobe period is therefore (prescale + 1) × (divide + 1) clock cycles. With both codes at zero, the strobe is high on every cycle.

A 4-bit preset selector can replace the two codes with one of sixteen built-in pairs. The pairs are chosen for common bit rates from a 48 MHz clock. For example, preset 5 divides by 13 × 2 = 26, which gives about 115.2 kbaud at 16x oversampling. A code change never resets a counter. The new code is loaded only when the affected stage next reaches its terminal count and reloads, so no short or extra strobe can appear.

Each stage is a two-state machine with a down-counter:
- `ST_DOWN` is entered while the count is non-zero.
- `ST_LAST` is entered while the count is zero.
- When the stage advances in `ST_DOWN` (the *count* transition), the counter decrements. It moves to `ST_LAST` (the *arrive* transition) when the count was one.
- When the stage advances in `ST_LAST`, it reloads its code. It moves to `ST_DOWN` (the *reload* transition) if the code is non-zero, or stays in `ST_LAST` (the *repeat* transition) if the code is zero.
- Synchronous reset performs the same load as a reload (the *reset load*).

The prescale stage advances on every cycle. The divide stage advances only on prescale terminal cycles.

Top module: `baud_tick16_gen`

## Requirements
- R1: A prescale code P (4 bits, `pre_field`) makes the first stage divide by P+1, so code 0 divides by 1 and code 15 divides by 16.
- R2: A divide code D (8 bits, `div_field`) makes the second stage divide by D+1. The steady spacing between strobes is (P+1)×(D+1) cycles, from 1 up to 4096.
- R3: `tick16` stays high for exactly one cycle whenever the overall ratio exceeds 1. With both codes at zero, it is high on every cycle.
- R4: While `rst` is high, `tick16` is low. After `rst` is released, the first strobe is high in the cycle that follows the N-th rising edge, where N is the overall ratio.
- R5: The divide stage moves only on prescale terminal cycles. Each stage counts down by one per advance, from its code to zero.
- R6: A code change takes effect at the next reload of each stage, with no extra pulse. Example: with codes P=3, D=3 (spacing 16), changing to P=1, D=1 in the cycle of a strobe gives a next spacing of exactly 10, then 4.
- R7: When `preset_en` is 1, `preset_sel` selects the codes and `pre_field`/`div_field` have no effect. Preset ratios (prescale×divide) are:
  - Indexes 0–3: 1×1, 1×2, 1×6, 1×16.
  - Indexes 4–15: 13 × 1, 2, 3, 4, 6, 12, 24, 48, 96, 192, 128, 256, in that order.
- R8: Preset 5 yields a spacing of 26 cycles, which is 16 × 115.2 kbaud from 48 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| preset_en | input | 1 | 1 selects the preset table instead of the raw codes |
| preset_sel | input | 4 | Preset table index |
| pre_field | input | 4 | Prescale code, ratio minus one |
| div_field | input | 8 | Divide code, ratio minus one |
| tick16 | output | 1 | One-cycle enable strobe at 16x the bit rate |

## Verification
The spacing and width assertions assume the codes in effect stay unchanged between the strobes they judge. They stand aside on any cycle where the effective codes differ from the previous cycle, and until one full strobe has passed since that change. The stimulus changes codes only during reset, or in the cycle of a strobe for the reload test. Every preset, and the extreme raw codes, are each held long enough to produce two clean spacings.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

    localparam int PRESET_PRE_W = 4;
    localparam int PRESET_DIV_W = 8;

    typedef enum logic {
        ST_DOWN = 1'b0,
        ST_LAST = 1'b1
    } stage_state_t;

    typedef struct packed {
        logic [PRESET_PRE_W-1:0] pre;
        logic [PRESET_DIV_W-1:0] div;
    } preset_codes_t;

    // Codes are stored as ratio minus one.
    function automatic preset_codes_t preset_lookup(input logic [3:0] sel);
        preset_codes_t c;
        unique case (sel)
            4'd0:  c = '{pre: 4'd0,  div: 8'd0};
            4'd1:  c = '{pre: 4'd0,  div: 8'd1};
            4'd2:  c = '{pre: 4'd0,  div: 8'd5};
            4'd3:  c = '{pre: 4'd0,  div: 8'd15};
            4'd4:  c = '{pre: 4'd12, div: 8'd0};
            4'd5:  c = '{pre: 4'd12, div: 8'd1};
            4'd6:  c = '{pre: 4'd12, div: 8'd2};
            4'd7:  c = '{pre: 4'd12, div: 8'd3};
            4'd8:  c = '{pre: 4'd12, div: 8'd5};
            4'd9:  c = '{pre: 4'd12, div: 8'd11};
            4'd10: c = '{pre: 4'd12, div: 8'd23};
            4'd11: c = '{pre: 4'd12, div: 8'd47};
            4'd12: c = '{pre: 4'd12, div: 8'd95};
            4'd13: c = '{pre: 4'd12, div: 8'd191};
            4'd14: c = '{pre: 4'd12, div: 8'd127};
            default: c = '{pre: 4'd12, div: 8'd255};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bg_stage.sv
module bg_stage
    import baud_gen_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic [W-1:0] reload,
    output logic         tc
);

    stage_state_t state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (adv) begin
            unique case (state_q)
                ST_DOWN: begin
                    cnt_d   = cnt_q - W'(1);
                    state_d = (cnt_q == W'(1)) ? ST_LAST : ST_DOWN;
                end
                ST_LAST: begin
                    cnt_d   = reload;
                    state_d = (reload == '0) ? ST_LAST : ST_DOWN;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= reload;
            state_q <= (reload == '0) ? ST_LAST : ST_DOWN;
        end else begin
            cnt_q   <= cnt_d;
            state_q <= state_d;
        end
    end

    // Output process
    always_comb begin
        tc = adv && (state_q == ST_LAST);
    end

    // R5
    countdown_step_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && state_q == ST_DOWN) |=> (cnt_q == $past(cnt_q) - W'(1)));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> ($stable(cnt_q) && $stable(state_q)));

    // R1
    last_is_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LAST) |-> (cnt_q == '0));

endmodule

// File: rtl/bg_preset_map.sv
module bg_preset_map
    import baud_gen_pkg::*;
(
    input  logic [3:0]              sel,
    output logic [PRESET_PRE_W-1:0] pre_code,
    output logic [PRESET_DIV_W-1:0] div_code
);

    preset_codes_t codes;

    always_comb begin
        codes    = preset_lookup(sel);
        pre_code = codes.pre;
        div_code = codes.div;
    end

endmodule

// File: rtl/baud_tick16_gen.sv
module baud_tick16_gen
    import baud_gen_pkg::*;
#(
    parameter int PRE_W = 4,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             preset_en,
    input  logic [3:0]       preset_sel,
    input  logic [PRE_W-1:0] pre_field,
    input  logic [DIV_W-1:0] div_field,
    output logic             tick16
);

    localparam int GAP_W = PRE_W + DIV_W + 1;

    logic [PRESET_PRE_W-1:0] map_pre;
    logic [PRESET_DIV_W-1:0] map_div;
    logic [PRE_W-1:0]        eff_pre;
    logic [DIV_W-1:0]        eff_div;
    logic                    pre_tc, div_tc;
    logic                    tick_q;

    bg_preset_map u_map (
        .sel      (preset_sel),
        .pre_code (map_pre),
        .div_code (map_div)
    );

    always_comb begin
        eff_pre = preset_en ? PRE_W'(map_pre) : pre_field;
        eff_div = preset_en ? DIV_W'(map_div) : div_field;
    end

    bg_stage #(.W(PRE_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .adv    (1'b1),
        .reload (eff_pre),
        .tc     (pre_tc)
    );

    bg_stage #(.W(DIV_W)) u_div (
        .clk    (clk),
        .rst    (rst),
        .adv    (pre_tc),
        .reload (eff_div),
        .tc     (div_tc)
    );

    always_ff @(posedge clk) begin
        if (rst) tick_q <= 1'b0;
        else     tick_q <= div_tc;
    end

    assign tick16 = tick_q;

    // ---------------- checker state ----------------
    logic [PRE_W-1:0] prev_pre;
    logic [DIV_W-1:0] prev_div;
    logic             fld_changed;
    logic [1:0]       seen_q;
    logic [GAP_W-1:0] gap_q;
    logic [GAP_W-1:0] period_n;

    always_comb begin
        fld_changed = (eff_pre != prev_pre) || (eff_div != prev_div);
        period_n    = (GAP_W'(eff_pre) + GAP_W'(1)) * (GAP_W'(eff_div) + GAP_W'(1));
    end

    always_ff @(posedge clk) begin
        prev_pre <= eff_pre;
        prev_div <= eff_div;
        if (rst) begin
            seen_q <= 2'd1;
            gap_q  <= '0;
        end else begin
            if (fld_changed)                    seen_q <= 2'd0;
            else if (tick_q && seen_q != 2'd3)  seen_q <= seen_q + 2'd1;
            if (tick_q)                         gap_q <= GAP_W'(1);
            else if (gap_q != '1)               gap_q <= gap_q + GAP_W'(1);
        end
    end

    // R2
    spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_q && seen_q != 2'd0 && !fld_changed) |-> (gap_q == period_n));

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_q && !fld_changed && period_n > GAP_W'(1) && seen_q != 2'd0) |=> !tick_q);

    // R3
    every_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_q && seen_q != 2'd0 && !fld_changed && period_n == GAP_W'(1)) |=> tick_q);

endmodule

// File: tb/baud_tick16_gen_test.sv
module baud_tick16_gen_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       preset_en = 1'b0;
    logic [3:0] preset_sel = '0;
    logic [3:0] pre_field = '0;
    logic [7:0] div_field = '0;
    logic       tick16;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    localparam int unsigned EXP_RATIO [16] = '{
        1, 2, 6, 16, 13, 26, 39, 52, 78, 156, 312, 624, 1248, 2496, 1664, 3328
    };

    baud_tick16_gen uut (
        .clk        (clk),
        .rst        (rst),
        .preset_en  (preset_en),
        .preset_sel (preset_sel),
        .pre_field  (pre_field),
        .div_field  (div_field),
        .tick16     (tick16)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired act=%0d exp<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Counts cycles up to and including the next cycle with tick16 high.
    task automatic measure(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n = n + 1;
        end while (!tick16 && n < 8000);
    endtask

    initial begin
        int n;

        // R4: strobe low while reset held
        rst = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check(tick16 == 1'b0, "R4 low in reset", int'(tick16), 0);
        end
        rst = 1'b0;

        // R3: both codes zero -> high every cycle, first in cycle 1
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check(tick16 == 1'b1, "R3 ratio one every cycle", int'(tick16), 1);
        end

        // R7/R8/R4: every preset, table walk
        for (int i = 0; i < 16; i++) begin
            preset_en  = 1'b1;
            preset_sel = 4'(i);
            pre_field  = 4'hF;
            div_field  = 8'h00;
            apply_reset();
            measure(n);
            check(n == int'(EXP_RATIO[i]), "R4 first strobe", n, int'(EXP_RATIO[i]));
            measure(n);
            if (i == 5)
                check(n == 26, "R8 preset 115.2k spacing", n, 26);
            else
                check(n == int'(EXP_RATIO[i]), "R7 preset spacing", n, int'(EXP_RATIO[i]));
            @(negedge clk);
            if (EXP_RATIO[i] > 1)
                check(tick16 == 1'b0, "R3 single cycle width", int'(tick16), 0);
        end

        // R7: raw codes ignored while preset selected
        preset_en  = 1'b1;
        preset_sel = 4'd3;
        pre_field  = 4'd2;
        div_field  = 8'd9;
        apply_reset();
        measure(n);
        pre_field = 4'd0;
        div_field = 8'd0;
        measure(n);
        check(n == 16, "R7 raw codes ignored", n, 16);
        measure(n);
        check(n == 16, "R7 raw codes ignored again", n, 16);

        // R1/R2/R5: raw codes
        preset_en = 1'b0;
        pre_field = 4'd2; div_field = 8'd4;
        apply_reset();
        measure(n); measure(n);
        check(n == 15, "R5 cascade 3x5", n, 15);

        pre_field = 4'd15; div_field = 8'd0;
        apply_reset();
        measure(n); measure(n);
        check(n == 16, "R1 prescale max", n, 16);

        pre_field = 4'd0; div_field = 8'd255;
        apply_reset();
        measure(n); measure(n);
        check(n == 256, "R2 divide max", n, 256);

        pre_field = 4'd15; div_field = 8'd255;
        apply_reset();
        measure(n);
        check(n == 4096, "R2 full ratio first", n, 4096);
        measure(n);
        check(n == 4096, "R2 full ratio", n, 4096);

        // R6: change in strobe cycle, takes effect at reload
        pre_field = 4'd3; div_field = 8'd3;
        apply_reset();
        measure(n);
        check(n == 16, "R6 before change", n, 16);
        pre_field = 4'd1; div_field = 8'd1;
        measure(n);
        check(n == 10, "R6 transition spacing", n, 10);
        measure(n);
        check(n == 4, "R6 new spacing", n, 4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule